// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block fetches the dwords of one script instruction from memory for a script-driven DMA engine. The memory bus must be owned before data can be read. The block therefore raises a request, waits for a grant, and takes each returned dword on a valid strobe. It releases ownership between groups of dwords. A fetch starts either when software loads the script pointer or when a start command arrives later; a manual-start setting selects which.

The first dword carries the instruction class, and the class sets how many dwords the instruction holds. In burst mode the first two dwords always arrive under one ownership, and the rest arrive under a second ownership. In single mode every dword gets its own ownership. When the last dword has arrived, the block pulses an instruction-complete strobe and presents all dwords, the dword count and the two address-space selects for the move. The pointer is then left on the next instruction.

Top module: `script_fetch_seq`

## Requirements
- R1: A synchronous reset puts the block in idle. After reset `bus_req` is low, `instr_done` is low and `fetch_addr` is 0.
- R2: With `manual_start` low, a `ptr_wr` in idle loads `ptr_data` into `fetch_addr`, and `bus_req` is high in the next cycle.
- R3: With `manual_start` high, a `ptr_wr` loads the pointer but leaves `bus_req` low. A later `start_dma` pulse raises `bus_req` in the next cycle.
- R4: The dword count comes from the first dword:
  - bits[31:30]=2'b11 gives 3 dwords;
  - bits[31:30]=2'b00 with bit 28 set gives 4 dwords;
  - bits[31:30]=2'b00 with bit 28 clear and bit 29 set gives 3 dwords;
  - any other first dword gives 2 dwords.
- R5: Burst mode is `burst_en` high and `burst_dis` low. In burst mode dwords 0 and 1 are taken under one ownership. Any remaining dwords (1 or 2) are taken under one later ownership.
- R6: When `burst_en` is low or `burst_dis` is high, each dword is taken under its own ownership.
- R7: After the last dword of a group is taken, `bus_req` is low for at least the following cycle.
- R8: A dword is taken only in a cycle with `bus_req`, `bus_gnt` and `rd_valid` all high. `fetch_addr` starts at the pointer and rises by 4 for each dword taken.
- R9: `instr_done` is high for exactly one cycle, in the cycle after the final dword is taken. At that point:
  - `instr_words` holds dword k at bits [32k+31:32k];
  - slots beyond the count are zero;
  - `instr_len` holds the count.
- R10: `src_is_io` and `dst_is_io` hold the values of `src_io_sel` and `dst_io_sel` captured when the fetch started. A value of 1 means I/O space and 0 means memory space.
- R11: While a fetch is in progress, `ptr_wr` and `start_dma` have no effect.
- R12: After an instruction completes, `fetch_addr` points just past it. A `start_dma` then fetches the next instruction from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ptr_wr | input | 1 | Script pointer write strobe |
| ptr_data | input | 32 | Script pointer value |
| manual_start | input | 1 | 1: a pointer write does not start a fetch |
| start_dma | input | 1 | Start command pulse |
| burst_en | input | 1 | Burst fetch enable |
| burst_dis | input | 1 | Global burst disable |
| src_io_sel | input | 1 | Source address space, 1 = I/O |
| dst_io_sel | input | 1 | Destination address space, 1 = I/O |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 32 | Read data dword |
| fetch_addr | output | 32 | Address of the dword being fetched |
| instr_done | output | 1 | Instruction complete pulse |
| instr_words | output | 128 | Fetched dwords, dword 0 in the low bits |
| instr_len | output | 3 | Number of dwords fetched |
| src_is_io | output | 1 | Captured source space select |
| dst_is_io | output | 1 | Captured destination space select |

## Verification
Errors in the dword index or the stored length show up first as a wrong grouping: ownerships start and end at the wrong dword. This is visible on `bus_req` within a cycle of the wrong decision. Such errors later also show as a wrong `instr_len` and a wrong `fetch_addr` at the completion pulse. A stuck state machine shows as `bus_req` held high or never raised, within one or two cycles of the start condition. A bad capture register shows in `instr_words` or in the space selects at the one-cycle completion strobe.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int DW      = 32;
  localparam int MAXW    = 4;
  localparam int IDX_W   = $clog2(MAXW);
  localparam int LEN_W   = $clog2(MAXW + 1);

  typedef enum logic [1:0] {S_IDLE, S_OWN, S_REL, S_DONE} seq_state_t;

  // Dword count of an instruction, derived from its first dword.
  function automatic logic [LEN_W-1:0] dword_count(input logic [DW-1:0] w);
    logic [LEN_W-1:0] n;
    if (w[DW-1:DW-2] == 2'b11)      n = LEN_W'(3);
    else if (w[DW-1:DW-2] == 2'b00) begin
      if (w[DW-4])                  n = LEN_W'(4);
      else if (w[DW-3])             n = LEN_W'(3);
      else                          n = LEN_W'(2);
    end
    else                            n = LEN_W'(2);
    return n;
  endfunction

  // A group closes after this dword when single mode is active, when the
  // second dword of a burst arrives, or when the instruction ends.
  function automatic logic closes_group(input logic burst,
                                        input logic [IDX_W-1:0] idx,
                                        input logic is_last);
    return !burst || (idx == IDX_W'(1)) || is_last;
  endfunction
endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
  import sfs_pkg::*;
(
  input  logic [DW-1:0]    first_word,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    len = dword_count(first_word);
    a_r4_len_range: assert (len >= LEN_W'(2) && len <= LEN_W'(MAXW))
      else $error("decoded length out of range");
  end
endmodule

// File: rtl/sfs_addr.sv
module sfs_addr #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr + AW'(STEP);
  end

  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr == $past(addr) + AW'(STEP)));
endmodule

// File: rtl/sfs_group.sv
module sfs_group
  import sfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             burst_in,
  input  logic             accept,
  input  logic [LEN_W-1:0] len_first,
  output logic [IDX_W-1:0] idx,
  output logic [LEN_W-1:0] total,
  output logic             grp_end,
  output logic             last_word
);
  logic             burst_q;
  logic [LEN_W-1:0] total_q;
  logic [LEN_W-1:0] total_eff;

  assign total_eff = (idx == '0) ? len_first : total_q;
  assign last_word = ({1'b0, idx} == total_eff - LEN_W'(1));
  assign grp_end   = closes_group(burst_q, idx, last_word);
  assign total     = total_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      total_q <= '0;
      burst_q <= 1'b0;
    end else if (start) begin
      idx     <= '0;
      total_q <= '0;
      burst_q <= burst_in;
    end else if (accept) begin
      idx <= idx + IDX_W'(1);
      if (idx == '0) total_q <= len_first;
    end
  end

  a_r5_first_not_last: assert property (@(posedge clk) disable iff (rst)
    (accept && idx == '0) |-> !last_word);
endmodule

// File: rtl/script_fetch_seq.sv
module script_fetch_seq
  import sfs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ptr_wr,
  input  logic [AW-1:0]      ptr_data,
  input  logic               manual_start,
  input  logic               start_dma,
  input  logic               burst_en,
  input  logic               burst_dis,
  input  logic               src_io_sel,
  input  logic               dst_io_sel,
  output logic               bus_req,
  input  logic               bus_gnt,
  input  logic               rd_valid,
  input  logic [DW-1:0]      rd_data,
  output logic [AW-1:0]      fetch_addr,
  output logic               instr_done,
  output logic [DW*MAXW-1:0] instr_words,
  output logic [LEN_W-1:0]   instr_len,
  output logic               src_is_io,
  output logic               dst_is_io
);
  localparam int STEP = DW / 8;

  seq_state_t       state, state_nx;
  logic             in_idle, go, accept, grp_end, last_word, burst_mode;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] len_first, total;
  logic [DW*MAXW-1:0] words_q;
  logic             src_q, dst_q;

  assign in_idle    = (state == S_IDLE);
  assign go         = in_idle && ((ptr_wr && !manual_start) || start_dma);
  assign accept     = (state == S_OWN) && bus_gnt && rd_valid;
  assign burst_mode = burst_en && !burst_dis;

  sfs_decode u_dec (.first_word(rd_data), .len(len_first));

  sfs_addr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk(clk), .rst(rst), .load(in_idle && ptr_wr), .load_val(ptr_data),
    .step(accept), .addr(fetch_addr));

  sfs_group u_grp (
    .clk(clk), .rst(rst), .start(go), .burst_in(burst_mode), .accept(accept),
    .len_first(len_first), .idx(idx), .total(total), .grp_end(grp_end),
    .last_word(last_word));

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE: if (go) state_nx = S_OWN;
      S_OWN:  if (accept && last_word)    state_nx = S_DONE;
              else if (accept && grp_end) state_nx = S_REL;
      S_REL:  state_nx = S_OWN;
      S_DONE: state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
      src_q   <= 1'b0;
      dst_q   <= 1'b0;
    end else if (go) begin
      words_q <= '0;
      src_q   <= src_io_sel;
      dst_q   <= dst_io_sel;
    end else if (accept) begin
      words_q[idx*DW +: DW] <= rd_data;
    end
  end

  assign bus_req     = (state == S_OWN);
  assign instr_done  = (state == S_DONE);
  assign instr_words = words_q;
  assign instr_len   = total;
  assign src_is_io   = src_q;
  assign dst_is_io   = dst_q;

  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    (accept && grp_end) |=> !bus_req);
  a_r5_hold_burst: assert property (@(posedge clk) disable iff (rst)
    (accept && !grp_end) |=> bus_req);
  a_r9_pulse_after_last: assert property (@(posedge clk) disable iff (rst)
    (accept && last_word) |=> instr_done);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !instr_done);
  a_r3_manual_hold: assert property (@(posedge clk) disable iff (rst)
    (in_idle && ptr_wr && manual_start && !start_dma) |=> !bus_req);
  a_r11_busy_addr: assert property (@(posedge clk) disable iff (rst)
    (!in_idle && !accept) |=> $stable(fetch_addr));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> (!bus_req && !instr_done));
endmodule

// File: tb/tb_script_fetch_seq.sv
module tb_script_fetch_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ptr_wr = 0, manual_start = 0, start_dma = 0;
  logic burst_en = 0, burst_dis = 0, src_io_sel = 0, dst_io_sel = 0;
  logic [31:0] ptr_data = '0;
  logic bus_req, bus_gnt = 0, rd_valid = 0;
  logic [31:0] rd_data = '0;
  logic [31:0] fetch_addr;
  logic instr_done;
  logic [127:0] instr_words;
  logic [2:0] instr_len;
  logic src_is_io, dst_is_io;

  always #4 clk = ~clk;

  script_fetch_seq dut (.*);

  int total_chk = 0, bad_chk = 0;
  logic [31:0] cur_ptr = 32'hFFFF_FFF0, cur_first = '0;
  int own_cnt = 0, grp_cnt = 0, pat = 0;
  logic prev_req = 0;

  // vector: first dword, burst_en, burst_dis, manual, src, dst
  localparam logic [36:0] VEC [8] = '{
    {32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {32'hC000_0011, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h2000_0022, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {32'h1000_0033, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {32'h3000_0044, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'hC000_0055, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_0066, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h8000_0077, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  function automatic int exp_len(input logic [31:0] w);
    if (w[31:30] == 2'b11) return 3;
    if (w[31:30] != 2'b00) return 2;
    if (w[28]) return 4;
    return w[29] ? 3 : 2;
  endfunction

  function automatic int exp_pat(input int n, input logic burst);
    int p = 0;
    if (burst) return (n == 2) ? 2 : (n == 3) ? 21 : 22;
    for (int k = 0; k < n; k++) p = p * 10 + 1;
    return p;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a == cur_ptr) ? cur_first : {8'hC5, a[23:0]};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total_chk++;
    if (act !== exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder and ownership monitor, acting on the falling edge
  always @(negedge clk) begin
    if (rst) begin
      bus_gnt = 0; rd_valid = 0; prev_req = 0;
    end else begin
      rd_valid = bus_req && bus_gnt;
      bus_gnt  = bus_req;
      rd_data  = word_at(fetch_addr);
      if (bus_req && !prev_req) own_cnt++;
      if (bus_req && bus_gnt && rd_valid) grp_cnt++;
      if (prev_req && !bus_req) begin pat = pat * 10 + grp_cnt; grp_cnt = 0; end
      prev_req = bus_req;
    end
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk); #1;
      if (instr_done) begin ok = 1; break; end
    end
    if (!ok) check("R9 done timeout", 0, 1);
  endtask

  task automatic verify(input int n, input logic burst, input logic s, input logic d);
    logic [127:0] ew = '0;
    for (int k = 0; k < n; k++) ew[k*32 +: 32] = word_at(cur_ptr + 32'(4*k));
    check("R4 length", 128'(instr_len), 128'(n));
    check("R9 words", instr_words, ew);
    check("R8 final address", 128'(fetch_addr), 128'(cur_ptr + 32'(4*n)));
    check("R10 space selects", {126'd0, src_is_io, dst_is_io}, {126'd0, s, d});
    check(burst ? "R5 burst grouping" : "R6 single grouping", 128'(pat), 128'(exp_pat(n, burst)));
    @(negedge clk); #1;
    check("R9 one-cycle pulse", 128'(instr_done), 0);
  endtask

  task automatic start_fetch(input logic [31:0] p, input logic [31:0] f, input logic man,
                             input logic be, input logic bd, input logic s, input logic d);
    @(negedge clk);
    cur_ptr = p; cur_first = f; own_cnt = 0; pat = 0; grp_cnt = 0;
    burst_en = be; burst_dis = bd; manual_start = man; src_io_sel = s; dst_io_sel = d;
    ptr_wr = 1; ptr_data = p;
    @(negedge clk); ptr_wr = 0; #1;
    if (man) begin
      check("R3 no request after manual pointer write", 128'(bus_req), 0);
      @(negedge clk); #1;
      check("R3 still idle", 128'(bus_req), 0);
      start_dma = 1;
      @(negedge clk); start_dma = 0; #1;
      check("R3 start command requests", 128'(bus_req), 1);
    end else begin
      check("R2 auto start requests", 128'(bus_req), 1);
    end
  endtask

  initial begin
    bit ok;
    logic [31:0] nxt;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset req", 128'(bus_req), 0);
    check("R1 reset done", 128'(instr_done), 0);
    check("R1 reset addr", 128'(fetch_addr), 0);
    rst = 0;

    for (int i = 0; i < 8; i++) begin
      logic [36:0] v = VEC[i];
      logic bm = v[4] && !v[3];
      start_fetch(32'h100 + 32'(i * 64), v[36:5], v[2], v[4], v[3], v[1], v[0]);
      wait_done(ok);
      if (ok) verify(exp_len(v[36:5]), bm, v[1], v[0]);
    end

    // R11: pointer write and start while busy
    start_fetch(32'h800, 32'h1000_0099, 0, 1, 0, 1, 1);
    @(negedge clk);
    ptr_wr = 1; ptr_data = 32'h0DEA_D000; start_dma = 1;
    @(negedge clk); ptr_wr = 0; start_dma = 0;
    wait_done(ok);
    if (ok) check("R11 busy write ignored", 128'(fetch_addr), 128'(32'h810));
    if (ok) verify(4, 1, 1, 1);

    // R12: continue with the next instruction
    nxt = fetch_addr;
    @(negedge clk);
    cur_ptr = nxt; cur_first = {8'hC5, nxt[23:0]}; own_cnt = 0; pat = 0; grp_cnt = 0;
    start_dma = 1;
    @(negedge clk); start_dma = 0; #1;
    check("R12 next fetch requests", 128'(bus_req), 1);
    wait_done(ok);
    if (ok) verify(3, 1, src_io_sel, dst_io_sel);

    // R7: release gap between groups in single mode
    start_fetch(32'h900, 32'h4000_0000, 0, 0, 0, 0, 0);
    wait_done(ok);
    check("R7 separate ownerships", 128'(own_cnt), 2);

    // R1: reset in the middle of a fetch
    start_fetch(32'hA00, 32'h1000_0000, 0, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1;
    @(negedge clk); #1;
    check("R1 mid-fetch reset req", 128'(bus_req), 0);
    check("R1 mid-fetch reset addr", 128'(fetch_addr), 0);
    rst = 0;

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad_chk++; total_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule